// File: doc/BRIEF.md
# Crate Command Register Bank

This block is the host-facing register file of a crate controller. A 32-bit host bus, with its strobes already brought into the controller clock domain as one-cycle write and read pulses, selects one of sixteen word registers. One register accepts a dataway command. That command is packed across both the address and the data of a single write: the station number and the top function bit come from the address, and the rest of the function code, the subaddress and the 24 write lines come from the data.

One address bit chooses between two outcomes for a command write. It can launch a dataway cycle, or it can only latch the fields so the host link can be tested without running the sequencer. The block keeps the command fields steady for the sequencer while a cycle runs. It collects the sequencer's read data and flags on its completion strobe. The host can read back the latched command, a status word and the live arbitration and LAM lines. A separate command register turns small action codes into single-clock control pulses or loads the LED outputs. A scratch register and a constant revision word let the host check the link.

Top module: `crate_regbank`

## Requirements
- R1: Address bits 15..12 pick the register. Read data appears on `bus_rdata` in the cycle after the `bus_rd` pulse and holds until the next read. Register 1 (write-only), register 3 and registers 8 to 15 read as zero.
- R2: Register 0 reads the `REV_WORD` parameter, and writes to it have no effect. Register 2 returns the last word written to it.
- R3: A command write goes to register 4. It sets station = address[8:4], function = {address[3], data[31:28]}, subaddress = data[27:24] and write lines = data[23:0] on the `cyc_*` outputs, starting in the cycle after the write.
- R4: A command write with address bit 2 = 1 raises `cyc_launch` for exactly one cycle, in the cycle after the write. With bit 2 = 0 the fields are latched and no launch occurs.
- R5: Register 4 reads back the last accepted command data word. Register 5 reads back the last accepted 16-bit command address in bits 15..0, with zero above.
- R6: A cycle is running from its launch until the completion strobe `seq_done_stb`. While it runs, any register 4 write is rejected: no launch, and the command outputs and the readback words stay unchanged.
- R7: Register 6 (status) holds: bit 31 done, bit 30 `arb_tmo`, bit 29 `idle_tmo`, bit 28 `busy_out` (these three are live inputs), bit 27 running, bit 26 new data, bit 25 captured `seq_accpt`, bit 24 captured `seq_resp`, and bits 23..0 captured read data.
- R8: An accepted launch clears done and new-data and sets running. A completion strobe sets done and new-data, clears running, and captures `seq_rdata`, `seq_resp` and `seq_accpt`.
- R9: When a start write arrives in the same cycle as the completion strobe that ends the running cycle, the strobe is applied and the write is rejected.
- R10: A write to register 1 uses the action code in data[7:0]. Codes 1 to 6 give a one-cycle pulse on `ctl_pulse[code-1]` (1 reset, 2 reconfigure, 3 test mode, 4 zero, 5 clear, 6 inhibit). Code 7 loads data[31:16] into `led_out`. Every other code changes no output.
- R11: Register 7 holds `line_flags[6:0]` in bits 31..25, zero in bit 24 and `lam_in` in bits 23..0. The flag order, from bit 31 down, is crate busy, inhibit, grant-in, grant-out, ACL, RI, RQ.
- R12: Synchronous reset clears the scratch register, the latched command and readbacks, the captured status, `led_out`, `ctl_pulse`, `cyc_launch` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | One-cycle host write pulse |
| bus_rd | input | 1 | One-cycle host read pulse |
| bus_addr | input | 16 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| cyc_launch | output | 1 | One-cycle start to the dataway sequencer |
| cyc_n | output | 5 | Latched station number |
| cyc_f | output | 5 | Latched function code |
| cyc_a | output | 4 | Latched subaddress |
| cyc_w | output | 24 | Latched write lines |
| seq_done_stb | input | 1 | Sequencer completion strobe |
| seq_rdata | input | 24 | Sequencer read data |
| seq_resp | input | 1 | Module response flag from the sequencer |
| seq_accpt | input | 1 | Command-accepted flag from the sequencer |
| arb_tmo | input | 1 | Arbitration timeout flag |
| idle_tmo | input | 1 | End-of-cycle idle timeout flag |
| busy_out | input | 1 | Busy-out line state |
| ctl_pulse | output | 6 | Action pulses for codes 1..6 |
| led_out | output | 16 | LED drive word |
| line_flags | input | 7 | Crate busy, inhibit, grant-in, grant-out, ACL, RI, RQ (bit 6 down to 0) |
| lam_in | input | 24 | Per-slot LAM lines |

## Verification
The completion strobe that ends a running cycle and a new start write can land on the same clock edge. That edge decides whether the new command replaces the fields the sequencer has just finished with. The bench drives `seq_done_stb` and a start write to register 4 in one cycle. It expects no `cyc_launch`, unchanged station bits and a status word with done set. It then repeats the write on its own and expects that write to be accepted. A second overlap, live timeout bits changing while captured flags are held, is judged by reading register 6 before and after a relaunch.

// File: rtl/crate_regbank_pkg.sv
package crate_regbank_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int WLINE_W = 24;
  localparam int IDX_W   = 4;

  localparam logic [IDX_W-1:0] IDX_REV    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_ACTION = 4'd1;
  localparam logic [IDX_W-1:0] IDX_SCR    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_CMD    = 4'd4;
  localparam logic [IDX_W-1:0] IDX_ADRB   = 4'd5;
  localparam logic [IDX_W-1:0] IDX_STAT   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_LINES  = 4'd7;

  localparam int START_BIT = 2;

  typedef struct packed {
    logic [4:0]         n;
    logic [4:0]         f;
    logic [3:0]         a;
    logic [WLINE_W-1:0] w;
  } dw_cmd_t;
endpackage

// File: rtl/crate_cmd_latch.sv
module crate_cmd_latch
  import crate_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_stb,
  output dw_cmd_t           cmd_q,
  output logic              launch_q,
  output logic              run_q,
  output logic              start_ok,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic accept;

  // a write is only taken while no cycle is outstanding
  assign accept   = cmd_wr && !run_q;
  assign start_ok = accept && addr[START_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      launch_q <= 1'b0;
      run_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      launch_q <= start_ok;
      if (start_ok)      run_q <= 1'b1;
      else if (done_stb) run_q <= 1'b0;
      if (accept) begin
        cmd_q.n <= addr[8:4];
        cmd_q.f <= {addr[3], wdata[31:28]};
        cmd_q.a <= wdata[27:24];
        cmd_q.w <= wdata[WLINE_W-1:0];
        addr_q  <= addr;
        data_q  <= wdata;
      end
    end
  end
endmodule

// File: rtl/crate_action_dec.sv
module crate_action_dec #(
  parameter int PULSE_CNT = 6,
  parameter int LED_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act_wr,
  input  logic [7:0]           code,
  input  logic [LED_W-1:0]     led_val,
  output logic [PULSE_CNT-1:0] pulse_q,
  output logic [LED_W-1:0]     led_q
);
  localparam logic [7:0] LED_CODE = 8'(PULSE_CNT + 1);

  for (genvar i = 0; i < PULSE_CNT; i++) begin : g_pulse
    localparam logic [7:0] MY_CODE = 8'(i + 1);
    always_ff @(posedge clk) begin
      if (rst) pulse_q[i] <= 1'b0;
      else     pulse_q[i] <= act_wr && (code == MY_CODE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             led_q <= '0;
    else if (act_wr && code == LED_CODE) led_q <= led_val;
  end
endmodule

// File: rtl/crate_stat_cap.sv
module crate_stat_cap
  import crate_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_ok,
  input  logic               done_stb,
  input  logic [WLINE_W-1:0] rdat,
  input  logic               resp,
  input  logic               accpt,
  output logic               done_q,
  output logic               resp_q,
  output logic               accpt_q,
  output logic [WLINE_W-1:0] rdat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      resp_q  <= 1'b0;
      accpt_q <= 1'b0;
      rdat_q  <= '0;
    end else begin
      if (start_ok)      done_q <= 1'b0;
      else if (done_stb) done_q <= 1'b1;
      if (done_stb) begin
        resp_q  <= resp;
        accpt_q <= accpt;
        rdat_q  <= rdat;
      end
    end
  end
endmodule

// File: rtl/crate_regbank.sv
module crate_regbank
  import crate_regbank_pkg::*;
#(
  parameter logic [31:0] REV_WORD  = 32'h2503_0117,
  parameter int          PULSE_CNT = 6,
  parameter int          LED_W     = 16,
  parameter int          FLAG_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 cyc_launch,
  output logic [4:0]           cyc_n,
  output logic [4:0]           cyc_f,
  output logic [3:0]           cyc_a,
  output logic [23:0]          cyc_w,
  input  logic                 seq_done_stb,
  input  logic [23:0]          seq_rdata,
  input  logic                 seq_resp,
  input  logic                 seq_accpt,
  input  logic                 arb_tmo,
  input  logic                 idle_tmo,
  input  logic                 busy_out,
  output logic [PULSE_CNT-1:0] ctl_pulse,
  output logic [LED_W-1:0]     led_out,
  input  logic [FLAG_W-1:0]    line_flags,
  input  logic [23:0]          lam_in
);
  localparam int LED_LSB = DATA_W - LED_W;
  localparam int PAD_W   = DATA_W - WLINE_W - FLAG_W;

  logic [IDX_W-1:0]   idx;
  dw_cmd_t            cmd;
  logic               cyc_running, start_ok;
  logic [ADDR_W-1:0]  last_addr;
  logic [DATA_W-1:0]  last_data;
  logic               done_q, resp_q, accpt_q;
  logic [WLINE_W-1:0] rdat_q;
  logic [DATA_W-1:0]  scratch_q, rd_mux, stat_word;

  assign idx = bus_addr[ADDR_W-1 -: IDX_W];

  crate_cmd_latch u_cmd (
    .clk(clk), .rst(rst),
    .cmd_wr(bus_wr && idx == IDX_CMD),
    .addr(bus_addr), .wdata(bus_wdata), .done_stb(seq_done_stb),
    .cmd_q(cmd), .launch_q(cyc_launch), .run_q(cyc_running),
    .start_ok(start_ok), .addr_q(last_addr), .data_q(last_data)
  );

  crate_action_dec #(.PULSE_CNT(PULSE_CNT), .LED_W(LED_W)) u_act (
    .clk(clk), .rst(rst),
    .act_wr(bus_wr && idx == IDX_ACTION),
    .code(bus_wdata[7:0]), .led_val(bus_wdata[DATA_W-1:LED_LSB]),
    .pulse_q(ctl_pulse), .led_q(led_out)
  );

  crate_stat_cap u_stat (
    .clk(clk), .rst(rst), .start_ok(start_ok), .done_stb(seq_done_stb),
    .rdat(seq_rdata), .resp(seq_resp), .accpt(seq_accpt),
    .done_q(done_q), .resp_q(resp_q), .accpt_q(accpt_q), .rdat_q(rdat_q)
  );

  assign cyc_n = cmd.n;
  assign cyc_f = cmd.f;
  assign cyc_a = cmd.a;
  assign cyc_w = cmd.w;

  // done and new-data share one flag; both bits report it
  assign stat_word = {done_q, arb_tmo, idle_tmo, busy_out,
                      cyc_running, done_q, accpt_q, resp_q, rdat_q};

  always_ff @(posedge clk) begin
    if (rst)                           scratch_q <= '0;
    else if (bus_wr && idx == IDX_SCR) scratch_q <= bus_wdata;
  end

  always_comb begin
    case (idx)
      IDX_REV:   rd_mux = REV_WORD;
      IDX_SCR:   rd_mux = scratch_q;
      IDX_CMD:   rd_mux = last_data;
      IDX_ADRB:  rd_mux = {{(DATA_W-ADDR_W){1'b0}}, last_addr};
      IDX_STAT:  rd_mux = stat_word;
      IDX_LINES: rd_mux = {line_flags, {PAD_W{1'b0}}, lam_in};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/crate_regbank_chk.sv
module crate_regbank_chk #(
  parameter int PULSE_CNT = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic [15:0]          bus_addr,
  input logic                 cyc_launch,
  input logic [4:0]           cyc_n,
  input logic [4:0]           cyc_f,
  input logic [3:0]           cyc_a,
  input logic [23:0]          cyc_w,
  input logic                 cyc_running,
  input logic                 seq_done_stb,
  input logic [PULSE_CNT-1:0] ctl_pulse
);
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cyc_launch |=> !cyc_launch); // R4

  AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cyc_launch |-> $past(bus_wr && bus_addr[15:12] == 4'd4 && bus_addr[2])); // R4

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(cyc_running) |-> $stable({cyc_n, cyc_f, cyc_a, cyc_w})); // R6

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_running && seq_done_stb) |=> !cyc_running); // R8

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_pulse)); // R10

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (|ctl_pulse) |-> $past(bus_wr && bus_addr[15:12] == 4'd1)); // R10
endmodule

bind crate_regbank crate_regbank_chk #(.PULSE_CNT(PULSE_CNT)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cyc_launch(cyc_launch), .cyc_n(cyc_n), .cyc_f(cyc_f), .cyc_a(cyc_a),
  .cyc_w(cyc_w), .cyc_running(cyc_running), .seq_done_stb(seq_done_stb),
  .ctl_pulse(ctl_pulse)
);

// File: tb/crate_regbank_bench.sv
module crate_regbank_bench;
  localparam logic [31:0] REV = 32'h2503_0117;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cyc_launch;
  logic [4:0]  cyc_n, cyc_f;
  logic [3:0]  cyc_a;
  logic [23:0] cyc_w;
  logic        seq_done_stb = 1'b0;
  logic [23:0] seq_rdata = '0;
  logic        seq_resp = 1'b0, seq_accpt = 1'b0;
  logic        arb_tmo = 1'b0, idle_tmo = 1'b0, busy_out = 1'b0;
  logic [5:0]  ctl_pulse;
  logic [15:0] led_out;
  logic [6:0]  line_flags = '0;
  logic [23:0] lam_in = '0;

  int checks = 0, fails = 0, launches = 0;

  always #10 clk = ~clk;

  crate_regbank #(.REV_WORD(REV)) u_crate_regbank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cyc_launch(cyc_launch), .cyc_n(cyc_n), .cyc_f(cyc_f), .cyc_a(cyc_a),
    .cyc_w(cyc_w), .seq_done_stb(seq_done_stb), .seq_rdata(seq_rdata),
    .seq_resp(seq_resp), .seq_accpt(seq_accpt), .arb_tmo(arb_tmo),
    .idle_tmo(idle_tmo), .busy_out(busy_out), .ctl_pulse(ctl_pulse),
    .led_out(led_out), .line_flags(line_flags), .lam_in(lam_in)
  );

  always @(posedge clk) if (!rst && cyc_launch) launches++;

  // {write, address, data, expected read}
  localparam logic [80:0] VEC [0:10] = '{
    {1'b0, 16'h0000, 32'h0000_0000, REV},
    {1'b1, 16'h2000, 32'hA5A5_5A5A, 32'h0},
    {1'b0, 16'h2000, 32'h0000_0000, 32'hA5A5_5A5A},
    {1'b1, 16'h2000, 32'h0000_FFFF, 32'h0},
    {1'b0, 16'h2000, 32'h0000_0000, 32'h0000_FFFF},
    {1'b0, 16'h1000, 32'h0000_0000, 32'h0},
    {1'b0, 16'hF000, 32'h0000_0000, 32'h0},
    {1'b1, 16'h40A8, 32'h3512_3456, 32'h0},
    {1'b0, 16'h4000, 32'h0000_0000, 32'h3512_3456},
    {1'b0, 16'h5000, 32'h0000_0000, 32'h0000_40A8},
    {1'b0, 16'h3000, 32'h0000_0000, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    seq_done_stb = 1'b1;
    @(negedge clk);
    seq_done_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R12 reset rdata", bus_rdata, 32'h0);
    chk("R12 reset launch/pulse/led", {15'h0, cyc_launch, ctl_pulse, led_out}, 32'h0);
    chk("R12 reset command", {3'h0, cyc_n, cyc_f, cyc_a, 15'h0}, 32'h0);
    rst = 1'b0;

    // R1 R2 R3 R5: table walk
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][80]) bus_write(VEC[i][79:64], VEC[i][63:32]);
      else begin
        bus_read(VEC[i][79:64], rd);
        chk($sformatf("R1/R2/R5 vector %0d", i), rd, VEC[i][31:0]);
      end
    end
    bus_write(16'h0000, 32'h1111_1111);
    bus_read(16'h0000, rd);
    chk("R2 revision not writable", rd, REV);
    chk("R3 fields n f a", {17'h0, cyc_n, cyc_f, cyc_a}, {17'h0, 5'd10, 5'd19, 4'd5});
    chk("R3 write lines", {8'h0, cyc_w}, 32'h0012_3456);
    chk("R4 test write gives no launch", launches, 0);

    // R4 launch
    bus_write(16'h4174, 32'h0012_3456);
    chk("R4 launch high after start write", {31'h0, cyc_launch}, 32'h1);
    chk("R3 station from address", {27'h0, cyc_n}, 32'd23);
    @(negedge clk);
    chk("R4 launch lasts one cycle", {31'h0, cyc_launch}, 32'h0);

    // R6 rejection while running
    bus_write(16'h4084, 32'hF100_0001);
    chk("R6 no launch while running", {31'h0, cyc_launch}, 32'h0);
    chk("R6 command held", {27'h0, cyc_n}, 32'd23);
    bus_read(16'h4000, rd);
    chk("R6 data readback held", rd, 32'h0012_3456);
    bus_read(16'h5000, rd);
    chk("R6 address readback held", rd, 32'h0000_4174);
    bus_read(16'h6000, rd);
    chk("R8 running bit", rd, 32'h0800_0000);

    // R8 completion capture
    seq_rdata = 24'hABCDEF; seq_resp = 1'b1; seq_accpt = 1'b1;
    done_pulse();
    bus_read(16'h6000, rd);
    chk("R7/R8 status after completion", rd, 32'h87AB_CDEF);
    arb_tmo = 1'b1; idle_tmo = 1'b1; busy_out = 1'b1;
    bus_read(16'h6000, rd);
    chk("R7 live timeout and busy-out bits", rd, 32'hF7AB_CDEF);
    arb_tmo = 1'b0; idle_tmo = 1'b0; busy_out = 1'b0;

    // R8 relaunch clears done and new-data
    bus_write(16'h4014, 32'h2100_0000);
    chk("R4 relaunch", {31'h0, cyc_launch}, 32'h1);
    chk("R3 function/subaddress", {22'h0, cyc_f, cyc_a, 1'b0}, {22'h0, 5'd2, 4'd1, 1'b0});
    bus_read(16'h6000, rd);
    chk("R8 status after relaunch", rd, 32'h0BAB_CDEF);

    // R9 completion and start write on the same edge
    seq_rdata = 24'h000111;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 16'h4024; bus_wdata = 32'h0; seq_done_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; seq_done_stb = 1'b0;
    chk("R9 no launch on collision", {31'h0, cyc_launch}, 32'h0);
    chk("R9 command kept", {27'h0, cyc_n}, 32'd1);
    bus_read(16'h6000, rd);
    chk("R9 completion applied", rd, 32'h8700_0111);
    bus_write(16'h4024, 32'h0);
    chk("R9 retry accepted", {26'h0, cyc_launch, cyc_n}, {26'h0, 1'b1, 5'd2});
    done_pulse();

    // R10 action codes
    for (int c = 1; c <= 6; c++) begin
      bus_write(16'h1000, 32'(c));
      chk($sformatf("R10 pulse code %0d", c), {26'h0, ctl_pulse}, 32'(1 << (c - 1)));
      @(negedge clk);
      chk($sformatf("R10 pulse %0d ends", c), {26'h0, ctl_pulse}, 32'h0);
    end
    bus_write(16'h1000, 32'hBEEF_0007);
    chk("R10 LED load", {16'h0, led_out}, 32'h0000_BEEF);
    bus_write(16'h1000, 32'h1234_0009);
    chk("R10 code 9 ignored", {10'h0, ctl_pulse, led_out}, {10'h0, 6'h0, 16'hBEEF});
    bus_write(16'h1000, 32'h5678_0000);
    chk("R10 code 0 ignored", {10'h0, ctl_pulse, led_out}, {10'h0, 6'h0, 16'hBEEF});

    // R11 line flags
    line_flags = 7'b1010101; lam_in = 24'h800001;
    bus_read(16'h7000, rd);
    chk("R11 flags and LAM", rd, 32'hAA80_0001);
    line_flags = '0; lam_in = '0;

    // R12 reset mid-run
    bus_write(16'h2000, 32'h0000_1234);
    bus_write(16'h4034, 32'h7700_0042);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R12 led and pulses cleared", {10'h0, ctl_pulse, led_out}, 32'h0);
    bus_read(16'h2000, rd);
    chk("R12 scratch cleared", rd, 32'h0);
    bus_read(16'h4000, rd);
    chk("R12 readback cleared", rd, 32'h0);
    bus_read(16'h6000, rd);
    chk("R12 status cleared", rd, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule